// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block keeps a short history of a digital loop's frequency control word so that, when the loop loses its reference, the oscillator can be steered by a value that is not already contaminated by a failing input. While the loop runs in normal mode and reports lock, an internal period counter fires a capture once per period. Each capture writes the live word into one of two slots, and the slots alternate.

When holdover begins, the block freezes the older of the two slots and presents it on its output for the whole holdover interval. The applied word was therefore captured between one and two capture periods before entry. If fewer than two captures have been taken since reset, no trustworthy history exists. In that case the valid flag stays low and a nominal freerun word is applied. Outside holdover the live word passes straight through.

Top module: `holdover_word_store`

## Requirements
- R1: A capture occurs on the last cycle of every PERIOD_CYC-cycle window counted from reset release, and successive captures write alternate slots.
- R2: On the first clock edge with `holdover_i` high, the block latches the older of the two most recent captures. From the next cycle `word_o` shows that value.
- R3: While holdover is active, `word_o` does not change, whatever `live_word_i` does.
- R4: No capture occurs in a window end where `lock_i` or `normal_i` is low, or where `holdover_i` is high.
- R5: If fewer than two captures preceded holdover entry, `valid_o` is low and `word_o` equals NOMINAL_WORD for the whole holdover interval.
- R6: Reset empties both slots, the slot toggle and the capture count, so `valid_o` is low after reset.
- R7: Outside holdover, `word_o` equals `live_word_i`, and `valid_o` is high once two captures have been taken.
- R8: Once `valid_o` is high, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Loop is locked to its reference |
| normal_i | input | 1 | Loop is in normal tracking mode |
| holdover_i | input | 1 | Holdover is requested (level) |
| live_word_i | input | W | Current frequency control word from the loop |
| word_o | output | W | Frequency word to apply |
| valid_o | output | 1 | A history of two captures backs the stored word |

## Verification
The hardest case to reach from the ports is a holdover entry that lands at a particular phase of the capture period. Entry can come just before or just after a window end, or after windows that were skipped because lock or normal mode was missing. The bench sweeps the entry cycle over three full periods. It combines the sweep with four lock and mode patterns, and it drives a new pseudo-random live word every cycle so that each capture is distinguishable. An independent newest/older history model then predicts the exact word that must be frozen.

// File: rtl/holdover_word_store.sv
module holdover_word_store #(
  parameter int W = 24,
  parameter int PERIOD_CYC = 6000000,
  parameter logic [W-1:0] NOMINAL_WORD = {1'b1, {(W-1){1'b0}}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock_i,
  input  logic         normal_i,
  input  logic         holdover_i,
  input  logic [W-1:0] live_word_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  slot0, slot1, held;
  logic          wsel, hold_q, held_ok;
  logic [1:0]    caps;

  wire tick    = (cnt == LAST);
  wire capture = tick & normal_i & lock_i & ~holdover_i;
  wire enter   = holdover_i & ~hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      slot0   <= '0;
      slot1   <= '0;
      wsel    <= 1'b0;
      caps    <= '0;
      hold_q  <= 1'b0;
      held    <= '0;
      held_ok <= 1'b0;
    end else begin
      cnt    <= tick ? '0 : cnt + 1'b1;
      hold_q <= holdover_i;
      if (capture) begin
        if (wsel) slot1 <= live_word_i;
        else      slot0 <= live_word_i;
        wsel <= ~wsel;
        if (caps != 2'd2) caps <= caps + 2'd1;
      end
      if (enter) begin
        held    <= wsel ? slot1 : slot0;
        held_ok <= (caps == 2'd2);
      end
    end
  end

  assign word_o  = hold_q ? (held_ok ? held : NOMINAL_WORD) : live_word_i;
  assign valid_o = hold_q ? held_ok : (caps == 2'd2);

  p_toggle_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel != $past(wsel)) |-> ($past(cnt) == LAST));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q) && $past(rst_n)) |-> $stable(word_o));

  p_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(normal_i && lock_i) || holdover_i) |=> ($stable(slot0) && $stable(slot1)));

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);

  p_entry_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover_i && !hold_q) |=> (held == $past(wsel ? slot1 : slot0)));
endmodule

// File: tb/holdover_word_store_tb.sv
module holdover_word_store_tb_top;
  localparam int W = 16;
  localparam int P = 8;
  localparam logic [W-1:0] NOM = 16'hA5C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock_i = 1'b0, normal_i = 1'b0, holdover_i = 1'b0;
  logic [W-1:0] live_word_i = '0;
  logic [W-1:0] word_o;
  logic valid_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  holdover_word_store #(.W(W), .PERIOD_CYC(P), .NOMINAL_WORD(NOM)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .normal_i(normal_i),
    .holdover_i(holdover_i), .live_word_i(live_word_i),
    .word_o(word_o), .valid_o(valid_o));

  // history model: newest/older shift of captured words, entry freezes older
  int m_phase;
  int m_ncap;
  logic [W-1:0] m_new, m_old, m_frz;
  logic m_in, m_frz_ok;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase <= 0; m_ncap <= 0; m_new <= '0; m_old <= '0;
      m_frz <= '0; m_in <= 1'b0; m_frz_ok <= 1'b0;
    end else begin
      m_phase <= (m_phase + 1) % P;
      if (m_phase == P - 1 && normal_i && lock_i && !holdover_i) begin
        m_old <= m_new; m_new <= live_word_i; m_ncap <= m_ncap + 1;
      end
      if (holdover_i && !m_in) begin
        m_frz <= m_old; m_frz_ok <= (m_ncap >= 2);
      end
      m_in <= holdover_i;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [W-1:0] lfsr = 16'h1ACE;
  task automatic drive(input int mode);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    live_word_i = lfsr;
    lock_i   = (mode == 2) ? 1'b0 : (mode == 1) ? (((cyc / P) % 2) == 0) : 1'b1;
    normal_i = (mode == 3) ? (((cyc / P) % 2) == 1) : 1'b1;
    cyc++;
  endtask

  task automatic run_case(input int mode, input int entry);
    logic [W-1:0] first;
    rst_n = 1'b0; holdover_i = 1'b0; cyc = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R6 valid after reset", {15'd0, valid_o}, 16'd0);
    for (int i = 0; i < entry; i++) begin
      @(negedge clk);
      // R7: pass-through and valid outside holdover (R1/R4 via model captures)
      check("R7 live pass", word_o, live_word_i);
      check("R7 valid", {15'd0, valid_o}, {15'd0, m_ncap >= 2});
      drive(mode);
    end
    holdover_i = 1'b1; normal_i = 1'b0;
    @(negedge clk);
    first = word_o;
    for (int i = 0; i < 10; i++) begin
      if (m_frz_ok) check("R2 frozen older word", word_o, m_frz);
      else          check("R5 nominal word", word_o, NOM);
      check("R5 valid in holdover", {15'd0, valid_o}, {15'd0, m_frz_ok});
      check("R3 stable in holdover", word_o, first);
      drive(mode); normal_i = 1'b0;
      @(negedge clk);
    end
    holdover_i = 1'b0; normal_i = 1'b1;
    @(negedge clk);
    drive(mode);
    #0.1;
    check("R7 live after exit", word_o, live_word_i);
    check("R8 valid kept", {15'd0, valid_o}, {15'd0, m_ncap >= 2});
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        for (int mode = 0; mode < 4; mode++)
          for (int e = 0; e <= 3 * P; e++)
            run_case(mode, e);
      end
      begin
        while (wd < 150000) begin @(posedge clk); wd++; end
      end
    join_any
    if (wd >= 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule